// File: doc/BRIEF.md
# Serial Management Slave Agent

This block is the PHY-side agent on a two-wire management bus. The management clock and the bidirectional data line arrive as pad inputs and are oversampled by the chip's system clock. Each rising edge of the management clock is turned into one sampled bit. A frame decoder works through these bits: a run of at least 32 ones, a `0`/`1` delimiter, a two-bit operation code, a five-bit station address, a five-bit register index, a two-bit bus handover and a sixteen-bit data field. All multi-bit fields are sent most significant bit first.

Only frames whose station address equals the strap input `phy_addr` are served. A read makes the block take over the shared line from the second handover bit through the last data bit. The output is retimed so that it changes only after a falling management-clock edge. A write updates an internal set of 16-bit registers and pulses a one-cycle update port toward the rest of the PHY. The set contains:

- a control word whose top bit clears itself;
- a status word that carries the live link bit;
- two fixed identifier words;
- a writable advertisement word;
- a word that mirrors the link partner's abilities;
- a fixed expansion word;
- seven writable vendor words.

Top module: `mdio_slave`

## Requirements
- R1: A frame begins only after at least 32 consecutive sampled ones followed by a `0` and then a `1`. If fewer ones precede the `0`, the frame is dropped, with no line drive and no register update.
- R2: Operation code `10` is a read and `01` is a write. Codes `00` and `11` drop the frame, so no register changes.
- R3: The block answers only when the five station-address bits equal `phy_addr`. Otherwise `mdio_oe` stays low and no register changes.
- R4: On a matched read, `mdio_oe` is still low when the first handover bit is sampled. The slave then drives `0` for the second handover bit.
- R5: On a matched read, the sixteen data bits appear MSB first on successive rising management-clock edges. `mdio_oe` is low again by the rising edge after D0. Whenever `mdio_oe` is low, `mdio_o` is `0`.
- R6: A matched write to a writable register stores the data. It raises `cfg_we` for exactly one system clock, together with `cfg_addr`/`cfg_wdata`, on the rising edge that carries D0. The writable registers are 0, 4, 16, 17, 18, 21, 22, 23 and 24.
- R7: Register indices outside 0–6, 16–18 and 21–24 read as zero. Writes to them change nothing and raise no `cfg_we`.
- R8: Registers 1, 2, 3, 5 and 6 are read-only, so writes leave them unchanged and raise no `cfg_we`. Register 1 reads `STATUS_BASE` with bit 2 replaced by `link_up`. Registers 2 and 3 read `ID_HI`/`ID_LO`. Register 5 mirrors `partner_ability`. Register 6 reads `EXP_VAL`.
- R9: Bit 15 of register 0 clears itself one system clock after it is written. The other written bits of register 0 are kept.
- R10: `mdio_o` and `mdio_oe` change only in the clock cycle after a falling management-clock edge is detected, never while the management clock is high.
- R11: After reset, `mdio_oe` and `cfg_we` are low, register 0 reads `CTRL_RST`, register 4 reads `ADV_RST`, and the vendor registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the management bus |
| rst | input | 1 | Synchronous active-high reset |
| mdc | input | 1 | Management clock from the pad |
| mdio_i | input | 1 | Resolved level of the shared data line |
| mdio_o | output | 1 | Value the slave drives on the data line |
| mdio_oe | output | 1 | Tri-state enable for the data line pad |
| phy_addr | input | 5 | Strapped station address of this PHY |
| link_up | input | 1 | Live link state shown in register 1 bit 2 |
| partner_ability | input | 16 | Link partner ability word shown as register 5 |
| cfg_we | output | 1 | One-cycle pulse on a committed write |
| cfg_addr | output | 5 | Register index of the committed write |
| cfg_wdata | output | 16 | Data of the committed write |

## Verification
The bench goes after preamble lengths just below the minimum, and after forbidden operation codes that are otherwise well-formed frames. A decoder that counted ones loosely or took any code as a write would store data that a later read exposes. Foreign station addresses are mixed with reads and writes. A block that ignored the match would drive the shared line, which the scoreboard sees as a surprise response, or would pulse `cfg_we`. The read path is compared bit by bit, including the handover zero and the release after D0, so an off-by-one shift or a late release shows up directly. A count of line changes while the management clock is high catches output retimed on the wrong edge.

// File: rtl/mdio_slave_pkg.sv
package mdio_slave_pkg;

    localparam int PRE_MIN   = 32;
    localparam int DATA_W    = 16;
    localparam int IDX_W     = 5;
    localparam int ADDR_BITS = 2 * IDX_W;
    localparam int VND_N     = 7;
    localparam int CNT_W     = 4;
    localparam int ONES_W    = $clog2(PRE_MIN + 1);

    typedef enum logic [2:0] {
        S_PRE,
        S_SFD,
        S_OP,
        S_ADDR,
        S_TA,
        S_DATA
    } frm_state_e;

    typedef enum logic [1:0] {
        OPC_WR = 2'b01,
        OPC_RD = 2'b10
    } opc_e;

    typedef struct packed {
        logic oe;
        logic val;
    } drive_t;

    typedef struct packed {
        logic [IDX_W-1:0] phy;
        logic [IDX_W-1:0] idx;
    } frm_addr_t;

    function automatic logic [IDX_W-1:0] vnd_index(input int i);
        case (i)
            0:       return 5'd16;
            1:       return 5'd17;
            2:       return 5'd18;
            3:       return 5'd21;
            4:       return 5'd22;
            5:       return 5'd23;
            default: return 5'd24;
        endcase
    endfunction

    function automatic logic idx_writable(input logic [IDX_W-1:0] a);
        case (a)
            5'd0, 5'd4, 5'd16, 5'd17, 5'd18,
            5'd21, 5'd22, 5'd23, 5'd24: return 1'b1;
            default:                     return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/mdio_edge_sync.sv
module mdio_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic mdc,
    input  logic mdio_i,
    output logic rise,
    output logic fall,
    output logic bit_s
);
    logic [STAGES-1:0] mdc_sh;
    logic [STAGES-1:0] dat_sh;
    logic              mdc_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            mdc_sh <= '0;
            dat_sh <= '1;
            mdc_d  <= 1'b0;
        end else begin
            mdc_sh <= {mdc_sh[STAGES-2:0], mdc};
            dat_sh <= {dat_sh[STAGES-2:0], mdio_i};
            mdc_d  <= mdc_sh[STAGES-1];
        end
    end

    assign rise  =  mdc_sh[STAGES-1] & ~mdc_d;
    assign fall  = ~mdc_sh[STAGES-1] &  mdc_d;
    assign bit_s =  dat_sh[STAGES-1];
endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_slave_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rise,
    input  logic              fall,
    input  logic              bit_s,
    input  logic [IDX_W-1:0]  phy_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] wr_data,
    output logic              mdio_o,
    output logic              mdio_oe
);
    frm_state_e        state;
    logic [CNT_W-1:0]  cnt;
    logic [ONES_W-1:0] ones;
    logic [DATA_W-1:0] shreg;
    logic [DATA_W-1:0] rd_sh;
    logic              is_rd;
    logic              hit;
    drive_t            nxt;
    frm_addr_t         fa;
    logic [1:0]        opc;

    assign fa     = frm_addr_t'({shreg[ADDR_BITS-2:0], bit_s});
    assign opc    = {shreg[0], bit_s};
    assign rd_idx = wr_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_PRE;
            cnt     <= '0;
            ones    <= '0;
            shreg   <= '0;
            rd_sh   <= '0;
            is_rd   <= 1'b0;
            hit     <= 1'b0;
            nxt     <= '0;
            wr_en   <= 1'b0;
            wr_idx  <= '0;
            wr_data <= '0;
            mdio_o  <= 1'b0;
            mdio_oe <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (fall) begin
                mdio_o  <= nxt.val;
                mdio_oe <= nxt.oe;
            end
            if (rise) begin
                shreg <= {shreg[DATA_W-2:0], bit_s};
                case (state)
                    S_PRE: begin
                        if (bit_s) begin
                            if (ones != ONES_W'(PRE_MIN)) ones <= ones + 1'b1;
                        end else if (ones == ONES_W'(PRE_MIN)) begin
                            state <= S_SFD;
                        end else begin
                            ones <= '0;
                        end
                    end
                    S_SFD: begin
                        ones <= '0;
                        cnt  <= '0;
                        state <= bit_s ? S_OP : S_PRE;
                    end
                    S_OP: begin
                        if (cnt == CNT_W'(1)) begin
                            cnt <= '0;
                            if (opc == OPC_RD) begin
                                is_rd <= 1'b1;
                                state <= S_ADDR;
                            end else if (opc == OPC_WR) begin
                                is_rd <= 1'b0;
                                state <= S_ADDR;
                            end else begin
                                state <= S_PRE;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_ADDR: begin
                        if (cnt == CNT_W'(ADDR_BITS - 1)) begin
                            cnt    <= '0;
                            wr_idx <= fa.idx;
                            hit    <= (fa.phy == phy_addr);
                            state  <= S_TA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_TA: begin
                        if (cnt == '0) begin
                            cnt <= CNT_W'(1);
                            if (hit && is_rd) begin
                                nxt   <= '{oe: 1'b1, val: 1'b0};
                                rd_sh <= rd_data;
                            end
                        end else begin
                            cnt   <= '0;
                            state <= S_DATA;
                            if (hit && is_rd) begin
                                nxt   <= '{oe: 1'b1, val: rd_sh[DATA_W-1]};
                                rd_sh <= rd_sh << 1;
                            end
                        end
                    end
                    S_DATA: begin
                        if (hit && is_rd) begin
                            if (cnt == CNT_W'(DATA_W - 1)) nxt <= '0;
                            else nxt <= '{oe: 1'b1, val: rd_sh[DATA_W-1]};
                            rd_sh <= rd_sh << 1;
                        end
                        if (cnt == CNT_W'(DATA_W - 1)) begin
                            cnt   <= '0;
                            ones  <= '0;
                            state <= S_PRE;
                            if (hit && !is_rd) begin
                                wr_en   <= 1'b1;
                                wr_data <= {shreg[DATA_W-2:0], bit_s};
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: state <= S_PRE;
                endcase
            end
        end
    end
endmodule

// File: rtl/mdio_regfile.sv
module mdio_regfile
    import mdio_slave_pkg::*;
#(
    parameter logic [DATA_W-1:0] CTRL_RST    = 16'h3100,
    parameter logic [DATA_W-1:0] STATUS_BASE = 16'h7809,
    parameter logic [DATA_W-1:0] ID_HI       = 16'h1234,
    parameter logic [DATA_W-1:0] ID_LO       = 16'h5670,
    parameter logic [DATA_W-1:0] ADV_RST     = 16'h01E1,
    parameter logic [DATA_W-1:0] EXP_VAL     = 16'h0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic              link_up,
    input  logic [DATA_W-1:0] partner_ability,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] ctrl_q
);
    logic [DATA_W-1:0] adv_q;
    logic [DATA_W-1:0] vnd_q [VND_N];
    logic [DATA_W-1:0] status_w;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RST;
        end else if (wr_en && wr_idx == 5'd0) begin
            ctrl_q <= wr_data;
        end else if (ctrl_q[15]) begin
            ctrl_q[15] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                          adv_q <= ADV_RST;
        else if (wr_en && wr_idx == 5'd4) adv_q <= wr_data;
    end

    for (genvar g = 0; g < VND_N; g++) begin : g_vnd
        always_ff @(posedge clk) begin
            if (rst)                                  vnd_q[g] <= '0;
            else if (wr_en && wr_idx == vnd_index(g)) vnd_q[g] <= wr_data;
        end
    end

    always_comb begin
        status_w    = STATUS_BASE;
        status_w[2] = link_up;
    end

    always_comb begin
        rd_data = '0;
        case (rd_idx)
            5'd0: rd_data = ctrl_q;
            5'd1: rd_data = status_w;
            5'd2: rd_data = ID_HI;
            5'd3: rd_data = ID_LO;
            5'd4: rd_data = adv_q;
            5'd5: rd_data = partner_ability;
            5'd6: rd_data = EXP_VAL;
            default: begin
                for (int i = 0; i < VND_N; i++)
                    if (rd_idx == vnd_index(i)) rd_data = vnd_q[i];
            end
        endcase
    end
endmodule

// File: rtl/mdio_slave.sv
module mdio_slave
    import mdio_slave_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter logic [DATA_W-1:0] CTRL_RST    = 16'h3100,
    parameter logic [DATA_W-1:0] STATUS_BASE = 16'h7809,
    parameter logic [DATA_W-1:0] ID_HI       = 16'h1234,
    parameter logic [DATA_W-1:0] ID_LO       = 16'h5670,
    parameter logic [DATA_W-1:0] ADV_RST     = 16'h01E1,
    parameter logic [DATA_W-1:0] EXP_VAL     = 16'h0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mdc,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic [IDX_W-1:0]  phy_addr,
    input  logic              link_up,
    input  logic [DATA_W-1:0] partner_ability,
    output logic              cfg_we,
    output logic [IDX_W-1:0]  cfg_addr,
    output logic [DATA_W-1:0] cfg_wdata
);
    logic              mdc_rise;
    logic              mdc_fall;
    logic              bit_s;
    logic [IDX_W-1:0]  rd_idx;
    logic [DATA_W-1:0] rd_data;
    logic              wr_en;
    logic              wr_ok;
    logic [DATA_W-1:0] ctrl_q;

    mdio_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .mdc    (mdc),
        .mdio_i (mdio_i),
        .rise   (mdc_rise),
        .fall   (mdc_fall),
        .bit_s  (bit_s)
    );

    mdio_frame_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .rise     (mdc_rise),
        .fall     (mdc_fall),
        .bit_s    (bit_s),
        .phy_addr (phy_addr),
        .rd_data  (rd_data),
        .rd_idx   (rd_idx),
        .wr_en    (wr_en),
        .wr_idx   (cfg_addr),
        .wr_data  (cfg_wdata),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe)
    );

    assign wr_ok  = wr_en & idx_writable(cfg_addr);
    assign cfg_we = wr_ok;

    mdio_regfile #(
        .CTRL_RST    (CTRL_RST),
        .STATUS_BASE (STATUS_BASE),
        .ID_HI       (ID_HI),
        .ID_LO       (ID_LO),
        .ADV_RST     (ADV_RST),
        .EXP_VAL     (EXP_VAL)
    ) u_regs (
        .clk             (clk),
        .rst             (rst),
        .wr_en           (wr_ok),
        .wr_idx          (cfg_addr),
        .wr_data         (cfg_wdata),
        .rd_idx          (rd_idx),
        .link_up         (link_up),
        .partner_ability (partner_ability),
        .rd_data         (rd_data),
        .ctrl_q          (ctrl_q)
    );
endmodule

// File: rtl/mdio_slave_chk.sv
module mdio_slave_chk (
    input logic        clk,
    input logic        rst,
    input logic        mdc_rise,
    input logic        mdc_fall,
    input logic        mdio_o,
    input logic        mdio_oe,
    input logic        cfg_we,
    input logic [15:0] ctrl_q
);
    a_r10_oe_after_fall: assert property (@(posedge clk) disable iff (rst)
        !$stable(mdio_oe) |-> $past(mdc_fall));

    a_r10_o_after_fall: assert property (@(posedge clk) disable iff (rst)
        !$stable(mdio_o) |-> $past(mdc_fall));

    a_r5_quiet_low: assert property (@(posedge clk) disable iff (rst)
        !mdio_oe |-> !mdio_o);

    a_r9_ctrl_selfclear: assert property (@(posedge clk) disable iff (rst)
        ctrl_q[15] |=> !ctrl_q[15]);

    a_r6_we_single: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> !cfg_we);

    a_r6_we_on_rise: assert property (@(posedge clk) disable iff (rst)
        cfg_we |-> $past(mdc_rise));

    a_r11_reset_quiet: assert property (@(posedge clk)
        rst |=> (!mdio_oe && !cfg_we));
endmodule

bind mdio_slave mdio_slave_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .mdc_rise (mdc_rise),
    .mdc_fall (mdc_fall),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .cfg_we   (cfg_we),
    .ctrl_q   (ctrl_q)
);

// File: tb/mdio_slave_tb.sv
module mdio_slave_tb;
    localparam int H = 8;
    localparam logic [4:0] ME = 5'd3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mdc = 1'b0;
    logic        m_en = 1'b0;
    logic        m_val = 1'b1;
    logic        link_up = 1'b0;
    logic [15:0] partner = 16'h0000;
    logic        mdio_i;
    logic        mdio_o;
    logic        mdio_oe;
    logic        cfg_we;
    logic [4:0]  cfg_addr;
    logic [15:0] cfg_wdata;

    int n_chk = 0;
    int n_fail = 0;
    int oe_cnt = 0;
    int we_cnt = 0;
    int hi_chg = 0;
    logic [4:0]  last_wa;
    logic [15:0] last_wd;

    typedef struct {
        logic [15:0] d;
        string       tag;
    } exp_t;
    exp_t        exp_q[$];
    logic [16:0] act_q[$];
    logic        rel_q[$];

    always #2 clk = ~clk;

    assign mdio_i = mdio_oe ? mdio_o : (m_en ? m_val : 1'b1);

    mdio_slave u_dut (
        .clk             (clk),
        .rst             (rst),
        .mdc             (mdc),
        .mdio_i          (mdio_i),
        .mdio_o          (mdio_o),
        .mdio_oe         (mdio_oe),
        .phy_addr        (ME),
        .link_up         (link_up),
        .partner_ability (partner),
        .cfg_we          (cfg_we),
        .cfg_addr        (cfg_addr),
        .cfg_wdata       (cfg_wdata)
    );

    logic mdc_p = 1'b0;
    logic o_p = 1'b0;
    logic oe_p = 1'b0;
    always @(posedge clk) begin
        if (mdio_oe) oe_cnt <= oe_cnt + 1;
        if (cfg_we) begin
            we_cnt  <= we_cnt + 1;
            last_wa <= cfg_addr;
            last_wd <= cfg_wdata;
        end
        if (mdc && mdc_p && (mdio_o != o_p || mdio_oe != oe_p)) hi_chg <= hi_chg + 1;
        mdc_p <= mdc;
        o_p   <= mdio_o;
        oe_p  <= mdio_oe;
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Monitor: capture handover bit plus 16 data bits of every driven read
    initial begin
        forever begin
            logic [16:0] cap;
            @(posedge mdio_oe);
            for (int i = 16; i >= 0; i--) begin
                @(posedge mdc);
                cap[i] = mdio_oe ? mdio_o : 1'bx;
            end
            @(posedge mdc);
            rel_q.push_back(mdio_oe);
            act_q.push_back(cap);
        end
    end

    // Scoreboard comparator
    initial begin
        forever begin
            @(negedge clk);
            if (act_q.size() > 0) begin
                logic [16:0] a;
                logic        r;
                exp_t        e;
                a = act_q.pop_front();
                r = rel_q.pop_front();
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3 unexpected response", {15'd0, a}, 32'd0);
                end else begin
                    e = exp_q.pop_front();
                    check(a[16] === 1'b0, "R4 handover bit", {31'd0, a[16]}, 32'd0);
                    check(a[15:0] === e.d, e.tag, {16'd0, a[15:0]}, {16'd0, e.d});
                    check(r === 1'b0, "R5 release after D0", {31'd0, r}, 32'd0);
                end
            end
        end
    end

    task automatic send_bit(input logic en, input logic val);
        @(negedge clk);
        mdc   = 1'b0;
        m_en  = en;
        m_val = val;
        repeat (H) @(negedge clk);
        mdc = 1'b1;
        repeat (H) @(negedge clk);
    endtask

    task automatic frame(input int pre, input logic [1:0] op, input logic [4:0] phy,
                         input logic [4:0] ra, input logic [15:0] wd, input bit is_rd);
        for (int i = 0; i < pre; i++) send_bit(1'b1, 1'b1);
        send_bit(1'b1, 1'b0);
        send_bit(1'b1, 1'b1);
        for (int i = 1; i >= 0; i--) send_bit(1'b1, op[i]);
        for (int i = 4; i >= 0; i--) send_bit(1'b1, phy[i]);
        for (int i = 4; i >= 0; i--) send_bit(1'b1, ra[i]);
        if (is_rd) begin
            for (int i = 0; i < 18; i++) send_bit(1'b0, 1'b0);
        end else begin
            send_bit(1'b1, 1'b1);
            send_bit(1'b1, 1'b0);
            for (int i = 15; i >= 0; i--) send_bit(1'b1, wd[i]);
        end
        send_bit(1'b0, 1'b0);
        send_bit(1'b0, 1'b0);
        repeat (4) @(negedge clk);
    endtask

    task automatic rd(input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] e, input string tag);
        int oe0;
        oe0 = oe_cnt;
        if (phy == ME) exp_q.push_back('{d: e, tag: tag});
        frame(32, 2'b10, phy, ra, 16'h0, 1'b1);
        repeat (4) @(negedge clk);
        if (phy != ME) check(oe_cnt == oe0, tag, oe_cnt - oe0, 0);
    endtask

    task automatic wr(input int pre, input logic [1:0] op, input logic [4:0] phy, input logic [4:0] ra,
                      input logic [15:0] wd, input bit expect_we, input string tag);
        int we0;
        we0 = we_cnt;
        frame(pre, op, phy, ra, wd, 1'b0);
        check((we_cnt - we0) == (expect_we ? 1 : 0), tag, we_cnt - we0, expect_we ? 1 : 0);
        if (expect_we) begin
            check(last_wa == ra && last_wd == wd, {tag, " port"}, {11'd0, last_wa, last_wd}, {11'd0, ra, wd});
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        report();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(mdio_oe == 1'b0 && cfg_we == 1'b0, "R11 reset outputs", {30'd0, mdio_oe, cfg_we}, 0);

        rd(ME, 5'd0, 16'h3100, "R11 reg0 default");
        rd(ME, 5'd4, 16'h01E1, "R11 reg4 default");
        rd(ME, 5'd17, 16'h0000, "R11 vendor default");

        rd(ME, 5'd2, 16'h1234, "R8 id high");
        rd(ME, 5'd3, 16'h5670, "R8 id low");
        link_up = 1'b1;
        partner = 16'hA5C3;
        rd(ME, 5'd1, 16'h780D, "R8 status link bit");
        rd(ME, 5'd5, 16'hA5C3, "R8 partner mirror");
        rd(ME, 5'd6, 16'h0000, "R8 expansion");

        wr(32, 2'b01, ME, 5'd4, 16'h0DE1, 1'b1, "R6 write reg4");
        rd(ME, 5'd4, 16'h0DE1, "R6 readback reg4");
        wr(32, 2'b01, ME, 5'd16, 16'h8001, 1'b1, "R6 write reg16");
        wr(32, 2'b01, ME, 5'd24, 16'h4002, 1'b1, "R6 write reg24");
        rd(ME, 5'd16, 16'h8001, "R5 msb first reg16");
        rd(ME, 5'd24, 16'h4002, "R5 msb first reg24");

        wr(32, 2'b01, ME, 5'd0, 16'h9140, 1'b1, "R9 write reg0");
        rd(ME, 5'd0, 16'h1140, "R9 reset bit cleared");

        wr(32, 2'b01, ME, 5'd2, 16'hFFFF, 1'b0, "R8 write to id");
        rd(ME, 5'd2, 16'h1234, "R8 id unchanged");

        wr(32, 2'b01, ME, 5'd20, 16'h5A5A, 1'b0, "R7 write unimplemented");
        rd(ME, 5'd20, 16'h0000, "R7 unimplemented reads zero");
        rd(ME, 5'd7, 16'h0000, "R7 reg7 zero");

        wr(32, 2'b01, 5'd9, 5'd16, 16'h1111, 1'b0, "R3 foreign write");
        rd(ME, 5'd16, 16'h8001, "R3 reg16 kept");
        rd(5'd9, 5'd4, 16'h0000, "R3 foreign read no drive");

        send_bit(1'b1, 1'b0);
        wr(31, 2'b01, ME, 5'd17, 16'h2222, 1'b0, "R1 short preamble write");
        send_bit(1'b1, 1'b0);
        rd(ME, 5'd17, 16'h0000, "R1 reg17 untouched");

        wr(32, 2'b11, ME, 5'd18, 16'h3333, 1'b0, "R2 opcode 11");
        wr(32, 2'b00, ME, 5'd18, 16'h3333, 1'b0, "R2 opcode 00");
        rd(ME, 5'd18, 16'h0000, "R2 reg18 untouched");

        repeat (8) @(negedge clk);
        check(exp_q.size() == 0, "R4 all reads answered", exp_q.size(), 0);
        check(hi_chg == 0, "R10 no change while mdc high", hi_chg, 0);
        report();
    end
endmodule